// File: doc/BRIEF.md
# Hoisted-Load Conflict Tracker

This block lets a load be issued ahead of older stores whose addresses are still unknown when the code is scheduled. When such an early load issues, the block records its memory address in a slot picked by the destination register number. Every store that follows compares its address against all live slots and kills each slot that refers to the same memory word. Later, at the point where the load stood in the original program order, a verify operation names the same register. If the slot is still live, the early value is good and the slot is released. If it is not, the block raises a replay request. That request carries the register number and the saved address, so the surrounding pipeline can re-run the load.

The table depth, address width and word size are parameters. A verify result appears one cycle after the verify is presented. Memory and the register file are outside the block.

Top module: `ald_conflict_tracker`

## Requirements
- R1: After reset every slot is empty and all response outputs are low. A verify on any register then gives a replay request with address 0.
- R2: An early load installs its address in the slot of its destination register. A later verify on that register, with no conflicting store in between, gives `rsp_ok`=1 and `replay_req`=0.
- R3: A store whose word address equals a live slot's word address kills that slot. A later verify on it gives `replay_req`=1, with `replay_reg` equal to the verified register and `replay_addr` equal to the saved full load address.
- R4: Addresses are compared per word. The low log2(WORD_BYTES) bits (2 bits by default) are ignored, so a store that differs only in those bits conflicts. A store that differs in any higher bit does not.
- R5: A single store kills every live slot that holds its word, all in the same cycle.
- R6: A successful verify releases the slot, so a second verify on the same register gives a replay request.
- R7: A new early load to a register that already has a slot overwrites the address and makes the slot live again.
- R8: A store presented in the same cycle as a verify is treated as older than the verify. If it matches the verified slot, the verify gives a replay request.
- R9: A store presented in the same cycle as an early load is treated as older than that load. The newly installed slot stays live even when the words match.
- R10: An early load and a verify on the same register in the same cycle: the verify sees the slot as it was before that cycle, and afterwards the slot holds the new load, live.
- R11: `rsp_valid` is high exactly in the cycle after a verify is presented. In that cycle exactly one of `rsp_ok` and `replay_req` is high. In all other cycles both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Early load issues this cycle |
| ld_reg | input | REG_W (3) | Destination register of the early load |
| ld_addr | input | ADDR_W (16) | Byte address of the early load |
| st_valid | input | 1 | Store address is known this cycle |
| st_addr | input | ADDR_W (16) | Byte address of the store |
| chk_valid | input | 1 | Verify operation this cycle |
| chk_reg | input | REG_W (3) | Register being verified |
| rsp_valid | output | 1 | Verify result is present |
| rsp_ok | output | 1 | Early value is usable, slot released |
| replay_req | output | 1 | Load must be re-run |
| replay_reg | output | REG_W (3) | Register to refresh on replay |
| replay_addr | output | ADDR_W (16) | Address to reload on replay |

## Verification
The assertions assume the three operation classes can arrive in any combination in one cycle. They also assume register fields are always in range, which holds because the table depth is a power of two. No handshake is assumed. The random stimulus draws load and store addresses from a pool of four neighbouring words with random low bits, so word-level matches and sub-word differences happen often. It also draws loads, stores and verifies independently every cycle, so every same-cycle ordering case comes up. Directed steps add stores that differ from a slot only in an upper address bit.

// File: rtl/ald_pkg.sv
package ald_pkg;
   typedef enum logic [1:0] {
      RSP_IDLE   = 2'd0,
      RSP_GOOD   = 2'd1,
      RSP_REPLAY = 2'd2
   } rsp_kind_e;
endpackage

// File: rtl/ald_entry.sv
module ald_entry #(
   parameter int ADDR_W = 16,
   parameter int OFS_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              install,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              snoop,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              release_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              snoop_hit_o
);
   logic              valid_q;
   logic [ADDR_W-1:0] addr_q;
   logic              same_word;

   generate
      if (OFS_W == 0) begin : g_byte_cmp
         assign same_word = (addr_q == st_addr);
      end else begin : g_word_cmp
         assign same_word = (addr_q[ADDR_W-1:OFS_W] == st_addr[ADDR_W-1:OFS_W]);
      end
   endgenerate

   assign snoop_hit_o = snoop && valid_q && same_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
      end else if (install) begin
         valid_q <= 1'b1;
         addr_q  <= ld_addr;
      end else if (snoop_hit_o || release_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign addr_o  = addr_q;
endmodule

// File: rtl/ald_check_unit.sv
module ald_check_unit
   import ald_pkg::*;
#(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 16,
   parameter int REG_W    = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             chk_valid,
   input  logic [REG_W-1:0]                 chk_reg,
   input  logic [NUM_REGS-1:0]              ent_valid,
   input  logic [NUM_REGS-1:0]              ent_hit,
   input  logic [NUM_REGS-1:0][ADDR_W-1:0]  ent_addr,
   output logic                             rsp_valid,
   output logic                             rsp_ok,
   output logic                             replay_req,
   output logic [REG_W-1:0]                 replay_reg,
   output logic [ADDR_W-1:0]                replay_addr
);
   rsp_kind_e         kind_d, kind_q;
   logic [REG_W-1:0]  reg_q;
   logic [ADDR_W-1:0] addr_q;

   always_comb begin
      kind_d = RSP_IDLE;
      if (chk_valid) begin
         if (ent_valid[chk_reg] && !ent_hit[chk_reg]) kind_d = RSP_GOOD;
         else                                         kind_d = RSP_REPLAY;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= RSP_IDLE;
         reg_q  <= '0;
         addr_q <= '0;
      end else begin
         kind_q <= kind_d;
         if (chk_valid) begin
            reg_q  <= chk_reg;
            addr_q <= ent_addr[chk_reg];
         end
      end
   end

   assign rsp_valid   = (kind_q != RSP_IDLE);
   assign rsp_ok      = (kind_q == RSP_GOOD);
   assign replay_req  = (kind_q == RSP_REPLAY);
   assign replay_reg  = reg_q;
   assign replay_addr = addr_q;
endmodule

// File: rtl/ald_conflict_tracker.sv
module ald_conflict_tracker #(
   parameter int NUM_REGS   = 8,
   parameter int ADDR_W     = 16,
   parameter int WORD_BYTES = 4,
   localparam int REG_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int OFS_W     = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid,
   input  logic [REG_W-1:0]  ld_reg,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              chk_valid,
   input  logic [REG_W-1:0]  chk_reg,
   output logic              rsp_valid,
   output logic              rsp_ok,
   output logic              replay_req,
   output logic [REG_W-1:0]  replay_reg,
   output logic [ADDR_W-1:0] replay_addr
);
   generate
      if (NUM_REGS < 2 || (1 << REG_W) != NUM_REGS) begin : g_bad_depth
         $error("NUM_REGS must be a power of two of at least 2");
      end
      if ((1 << OFS_W) != WORD_BYTES) begin : g_bad_word
         $error("WORD_BYTES must be a power of two");
      end
      if (OFS_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the word offset width");
      end
   endgenerate

   logic [NUM_REGS-1:0]             ent_valid;
   logic [NUM_REGS-1:0]             ent_hit;
   logic [NUM_REGS-1:0][ADDR_W-1:0] ent_addr;

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
         logic install, release_s;
         assign install   = ld_valid  && (ld_reg  == REG_W'(i));
         assign release_s = chk_valid && (chk_reg == REG_W'(i));
         ald_entry #(
            .ADDR_W (ADDR_W),
            .OFS_W  (OFS_W)
         ) u_entry (
            .clk         (clk),
            .rst_n       (rst_n),
            .install     (install),
            .ld_addr     (ld_addr),
            .snoop       (st_valid),
            .st_addr     (st_addr),
            .release_i   (release_s),
            .valid_o     (ent_valid[i]),
            .addr_o      (ent_addr[i]),
            .snoop_hit_o (ent_hit[i])
         );
      end
   endgenerate

   ald_check_unit #(
      .NUM_REGS (NUM_REGS),
      .ADDR_W   (ADDR_W),
      .REG_W    (REG_W)
   ) u_check (
      .clk         (clk),
      .rst_n       (rst_n),
      .chk_valid   (chk_valid),
      .chk_reg     (chk_reg),
      .ent_valid   (ent_valid),
      .ent_hit     (ent_hit),
      .ent_addr    (ent_addr),
      .rsp_valid   (rsp_valid),
      .rsp_ok      (rsp_ok),
      .replay_req  (replay_req),
      .replay_reg  (replay_reg),
      .replay_addr (replay_addr)
   );
endmodule

// File: rtl/ald_conflict_tracker_chk.sv
module ald_conflict_tracker_chk #(
   parameter int NUM_REGS = 8,
   parameter int ADDR_W   = 16,
   parameter int REG_W    = 3,
   parameter int OFS_W    = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            ld_valid,
   input logic [REG_W-1:0]                ld_reg,
   input logic [ADDR_W-1:0]               ld_addr,
   input logic                            st_valid,
   input logic [ADDR_W-1:0]               st_addr,
   input logic                            chk_valid,
   input logic [REG_W-1:0]                chk_reg,
   input logic                            rsp_valid,
   input logic                            rsp_ok,
   input logic                            replay_req,
   input logic [REG_W-1:0]                replay_reg,
   input logic [NUM_REGS-1:0]             ent_valid,
   input logic [NUM_REGS-1:0][ADDR_W-1:0] ent_addr
);
   AST_RSP_FOLLOWS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> rsp_valid);                                   // R11
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> !rsp_ok && !replay_req);                     // R11
   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $countones({rsp_ok, replay_req}) == 1);       // R11
   AST_REPLAY_NAMES_REG: assert property (@(posedge clk) disable iff (!rst_n)
      chk_valid |=> replay_reg == $past(chk_reg));                // R3

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot_chk
         AST_LOAD_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
            ld_valid && ld_reg == REG_W'(i)
            |=> ent_valid[i] && ent_addr[i] == $past(ld_addr));   // R9
         AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
            st_valid && !(ld_valid && ld_reg == REG_W'(i))
            && st_addr[ADDR_W-1:OFS_W] == ent_addr[i][ADDR_W-1:OFS_W]
            |=> !ent_valid[i]);                                   // R5
         AST_CHECK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            chk_valid && chk_reg == REG_W'(i) && !(ld_valid && ld_reg == REG_W'(i))
            |=> !ent_valid[i]);                                   // R6
      end
   endgenerate
endmodule

bind ald_conflict_tracker ald_conflict_tracker_chk #(
   .NUM_REGS (NUM_REGS),
   .ADDR_W   (ADDR_W),
   .REG_W    (REG_W),
   .OFS_W    (OFS_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ld_valid   (ld_valid),
   .ld_reg     (ld_reg),
   .ld_addr    (ld_addr),
   .st_valid   (st_valid),
   .st_addr    (st_addr),
   .chk_valid  (chk_valid),
   .chk_reg    (chk_reg),
   .rsp_valid  (rsp_valid),
   .rsp_ok     (rsp_ok),
   .replay_req (replay_req),
   .replay_reg (replay_reg),
   .ent_valid  (ent_valid),
   .ent_addr   (ent_addr)
);

// File: tb/ald_conflict_tracker_tb.sv
`timescale 1ns/1ps
module ald_conflict_tracker_tb;
   localparam int NR = 8;
   localparam int AW = 16;
   localparam int RW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_valid = 1'b0, st_valid = 1'b0, chk_valid = 1'b0;
   logic [RW-1:0] ld_reg = '0, chk_reg = '0;
   logic [AW-1:0] ld_addr = '0, st_addr = '0;
   logic          rsp_valid, rsp_ok, replay_req;
   logic [RW-1:0] replay_reg;
   logic [AW-1:0] replay_addr;

   always #2 clk = ~clk;

   ald_conflict_tracker u_dut (
      .clk(clk), .rst_n(rst_n),
      .ld_valid(ld_valid), .ld_reg(ld_reg), .ld_addr(ld_addr),
      .st_valid(st_valid), .st_addr(st_addr),
      .chk_valid(chk_valid), .chk_reg(chk_reg),
      .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .replay_req(replay_req),
      .replay_reg(replay_reg), .replay_addr(replay_addr)
   );

   int n_chk = 0;
   int n_bad = 0;

   // reference table
   bit            mv [NR];
   logic [AW-1:0] ma [NR];

   // expectation for the response due after the current step
   bit            e_vld, e_ok;
   logic [RW-1:0] e_reg;
   logic [AW-1:0] e_addr;
   string         e_tag = "R1";

   function automatic bit same_word(logic [AW-1:0] a, logic [AW-1:0] b);
      return a[AW-1:2] == b[AW-1:2];
   endfunction

   task automatic compare();
      bit bad;
      n_chk++;
      bad = (rsp_valid !== e_vld) || (rsp_ok !== (e_vld && e_ok))
         || (replay_req !== (e_vld && !e_ok));
      if (e_vld && !e_ok)
         bad = bad || (replay_reg !== e_reg) || (replay_addr !== e_addr);
      if (bad) begin
         n_bad++;
         $display("FAIL %s: got vld=%0b ok=%0b rp=%0b reg=%0d addr=%h exp vld=%0b ok=%0b rp=%0b reg=%0d addr=%h",
                  e_tag, rsp_valid, rsp_ok, replay_req, replay_reg, replay_addr,
                  e_vld, e_vld && e_ok, e_vld && !e_ok, e_reg, e_addr);
      end
   endtask

   // one cycle: compare the previous step's response, then drive a new one
   task automatic step(input string tag, input bit ld, input int lr, input logic [AW-1:0] la,
                       input bit st, input logic [AW-1:0] sa, input bit ck, input int cr);
      @(negedge clk);
      compare();
      ld_valid = ld; ld_reg = RW'(lr); ld_addr = la;
      st_valid = st; st_addr = sa;
      chk_valid = ck; chk_reg = RW'(cr);
      e_tag = tag;
      e_vld = ck;
      e_ok  = ck && mv[cr] && !(st && same_word(sa, ma[cr]));
      e_reg = RW'(cr);
      e_addr = ma[cr];
      for (int i = 0; i < NR; i++) begin
         if (ld && lr == i) begin
            mv[i] = 1'b1; ma[i] = la;
         end else if ((st && mv[i] && same_word(sa, ma[i])) || (ck && cr == i)) begin
            mv[i] = 1'b0;
         end
      end
   endtask

   task automatic idle(input string tag);
      step(tag, 0, 0, '0, 0, '0, 0, 0);
   endtask

   function automatic logic [AW-1:0] pick_addr();
      return AW'(16'h0100 + (($urandom % 4) << 2) + ($urandom % 4));
   endfunction

   initial begin
      #(4 * 200000);
      n_bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < NR; i++) begin mv[i] = 0; ma[i] = '0; end
      e_vld = 0; e_ok = 0; e_reg = '0; e_addr = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state, then verify on an empty slot
      step("R1", 0, 0, '0, 0, '0, 1, 3);
      idle("R1");
      // R2: install and verify cleanly
      step("R2", 1, 1, 16'h0120, 0, '0, 0, 0);
      step("R2", 0, 0, '0, 0, '0, 1, 1);
      // R6: second verify on a released slot replays
      step("R6", 0, 0, '0, 0, '0, 1, 1);
      idle("R6");
      // R3: store to same word kills, replay carries reg and address
      step("R3", 1, 5, 16'h0208, 0, '0, 0, 0);
      step("R3", 0, 0, '0, 1, 16'h0208, 0, 0);
      step("R3", 0, 0, '0, 0, '0, 1, 5);
      // R4: low bits ignored, upper bit matters
      step("R4", 1, 2, 16'h0104, 0, '0, 0, 0);
      step("R4", 1, 3, 16'h0200, 1, 16'h0107, 0, 0);
      step("R4", 0, 0, '0, 1, 16'h0600, 1, 2);
      step("R4", 0, 0, '0, 0, '0, 1, 3);
      // R5: one store kills several slots
      step("R5", 1, 4, 16'h0300, 0, '0, 0, 0);
      step("R5", 1, 6, 16'h0302, 0, '0, 0, 0);
      step("R5", 1, 7, 16'h0310, 1, 16'h0301, 0, 0);
      step("R5", 0, 0, '0, 0, '0, 1, 4);
      step("R5", 0, 0, '0, 0, '0, 1, 6);
      step("R5", 0, 0, '0, 0, '0, 1, 7);
      // R7: overwrite with new address revives slot
      step("R7", 1, 0, 16'h0400, 0, '0, 0, 0);
      step("R7", 0, 0, '0, 1, 16'h0400, 0, 0);
      step("R7", 1, 0, 16'h0440, 0, '0, 0, 0);
      step("R7", 0, 0, '0, 1, 16'h0400, 1, 0);
      // R8: store in the verify cycle counts
      step("R8", 1, 1, 16'h0500, 0, '0, 0, 0);
      step("R8", 0, 0, '0, 1, 16'h0503, 1, 1);
      // R9: store in the load cycle does not kill the new slot
      step("R9", 1, 2, 16'h0600, 1, 16'h0600, 0, 0);
      step("R9", 0, 0, '0, 0, '0, 1, 2);
      // R10: load and verify same register same cycle
      step("R10", 1, 3, 16'h0700, 0, '0, 1, 3);
      step("R10", 0, 0, '0, 0, '0, 1, 3);
      idle("R10");
      // random mix, R11 covers timing and verdict shape
      for (int n = 0; n < 3000; n++) begin
         step("R11", ($urandom % 3) == 0, $urandom % NR, pick_addr(),
              ($urandom % 3) == 0, pick_addr(), ($urandom % 2) == 0, $urandom % NR);
      end
      idle("R11");
      idle("R11");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule